// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and date as packed BCD bytes: seconds, minutes, hours, weekday, day of month, month and a two-digit year. An external prescaler supplies a single-cycle `tick` pulse once per second. Each tick the block advances the seconds and carries into the higher fields. The day-of-month limit depends on the month and on leap years.

Software uses a byte-wide register port. It stops the counters through a run bit, loads new field values, and restarts them. The run bit reads back its new value only once the change has passed the internal synchronizer. A clear request returns every field to its initial value and reports itself busy while it runs. A carry flag is set by every advance. Software can clear the flag, read all fields, and retry the read if the flag came back. The hour field runs either as 00–23, or as 12, 01–11 with a PM bit.

Top module: `bcd_clock_calendar`

## Requirements
- R1: After reset the fields read sec 0x00, min 0x00, hour 0x12 (12-hour mode, AM), weekday 0x00, day 0x01, month 0x01, year 0x00, and the control and status registers read 0x00. Register addresses are: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year, 8 control, 9 status.
- R2: Seconds and minutes count in BCD from 0x00 to 0x59. Each wraps to 0x00 and advances the next field, and a BCD digit carry (for example 0x09 to 0x10) is handled.
- R3: In 24-hour mode (control bit 6 = 1) the hour field counts 0x00 to 0x23. After 23:59:59 it becomes 0x00 and the date advances.
- R4: In 12-hour mode (control bit 6 = 0) the hour field holds 0x01–0x12 in bits 5:0, with PM in bit 6. 12 is followed by 01. At each 11:59:59 to 12:00:00 step the PM bit toggles. The date advances only when the step leaves PM.
- R5: The day wraps to 0x01 after 0x28/0x29, 0x30 or 0x31 according to the month, and advances the month. Month 0x12 wraps to 0x01 and advances the year, and year 0x99 wraps to 0x00.
- R6: A year whose value is divisible by 4 (00 included) gives February 29 days; other years give February 28.
- R7: The weekday advances with the day from 0 to 6 and wraps to 0.
- R8: Control bit 0 gates counting. A written value appears in the control readback and in the counting behaviour after SYNC_STAGES further clock cycles. Ticks seen while the readback is 0 change nothing.
- R9: Writes to field registers take effect only while the run readback is 0. Writes made while running leave the field unchanged.
- R10: Status bit 1 is set by every counted tick. Writing the status register with bit 1 = 0 clears it, and writing bit 1 = 1 leaves it unchanged. A tick in the same cycle as a clearing write wins.
- R11: Writing control bit 1 = 1 makes control bit 1 read 1 for CLR_CYCLES cycles. During that time all fields return to their R1 values, except that the hour returns to 0x00 in 24-hour mode. Bit 1 then reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per second from the prescaler |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for reads and writes |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for `addr` |

## Verification
The bench builds the block with SYNC_STAGES = 2 and CLR_CYCLES = 4. With these values the start latency and the clear-busy window are short enough to count cycle by cycle and compare exactly with the parameters. The synchronizer stays deep enough that a stale readback directly after a write is observable. Directed cases cover year, month, leap-February and 12-hour PM boundaries. Randomly loaded dates in both hour modes then cover the rollover chain.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int FIELD_CNT = 7;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_WDAY = 3;
  localparam int F_DAY  = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;

  localparam int A_CTRL = 8;
  localparam int A_STAT = 9;

  // Strobes from the control side to the field datapath.
  typedef struct packed {
    logic                 advance;
    logic                 clear;
    logic                 mode24;
    logic [FIELD_CNT-1:0] load;
    logic [7:0]           data;
  } calStrobe_t;

  // Next packed BCD value, no wrap handling.
  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Writable bits of each field.
  function automatic logic [7:0] fieldMask(input int idx);
    case (idx)
      F_SEC, F_MIN, F_HOUR: return 8'h7f;
      F_WDAY:               return 8'h07;
      F_DAY:                return 8'h3f;
      F_MON:                return 8'h1f;
      default:              return 8'hff;
    endcase
  endfunction

  function automatic logic isLeap(input logic [7:0] yr);
    logic [6:0] bin;
    bin = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    return (bin % 7'd4) == 7'd0;
  endfunction

  // Last day of the month, packed BCD.
  function automatic logic [7:0] monthEnd(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return isLeap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
#(
  parameter int SYNC_STAGES = 3,
  parameter int CLR_CYCLES  = 16,
  parameter int ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output calStrobe_t        strb,
  output logic              runActive,
  output logic              clrBusy,
  output logic              mode24,
  output logic              carryFlag
);

  localparam int CLR_W = $clog2(CLR_CYCLES + 1);

  logic                   runReq;
  logic [SYNC_STAGES-1:0] runPipe;
  logic [CLR_W-1:0]       clrCnt;
  logic                   ctrlWr;
  logic                   statWr;

  assign ctrlWr    = wrEn && (addr == ADDR_W'(A_CTRL));
  assign statWr    = wrEn && (addr == ADDR_W'(A_STAT));
  assign runActive = runPipe[SYNC_STAGES-1];
  assign clrBusy   = (clrCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runReq <= 1'b0;
      mode24 <= 1'b0;
    end else if (ctrlWr) begin
      runReq <= wrData[0];
      mode24 <= wrData[6];
    end
  end

  generate
    if (SYNC_STAGES == 1) begin : gSyncOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) runPipe <= '0;
        else       runPipe <= runReq;
      end
    end else begin : gSyncChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) runPipe <= '0;
        else       runPipe <= {runPipe[SYNC_STAGES-2:0], runReq};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  clrCnt <= '0;
    else if (ctrlWr && wrData[1]) clrCnt <= CLR_W'(CLR_CYCLES);
    else if (clrBusy)           clrCnt <= clrCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        carryFlag <= 1'b0;
    else if (strb.advance)            carryFlag <= 1'b1;
    else if (statWr && !wrData[1])    carryFlag <= 1'b0;
  end

  always_comb begin
    strb.advance = tick && runActive && !clrBusy;
    strb.clear   = clrBusy;
    strb.mode24  = mode24;
    strb.data    = wrData;
  end

  generate
    for (genvar i = 0; i < FIELD_CNT; i++) begin : gLoad
      assign strb.load[i] = wrEn && (addr == ADDR_W'(i)) && !runActive && !clrBusy;
    end
  endgenerate

  AST_CARRY_ON_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> carryFlag) else $error("carry flag not set"); // R10

endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  calStrobe_t             strb,
  output logic [FIELD_CNT*8-1:0] fieldsFlat
);

  logic [7:0]           fq      [FIELD_CNT];
  logic [7:0]           stepVal [FIELD_CNT];
  logic [FIELD_CNT-1:0] stepEn;

  logic [7:0] secQ, minQ, hourQ, wdayQ, dayQ, monQ, yearQ;
  logic [7:0] hourInc, hourNext, dayEnd;
  logic       secWrap, minWrap, dayFromHour, dayWrap, dayCarry;

  assign secQ  = fq[F_SEC];
  assign minQ  = fq[F_MIN];
  assign hourQ = fq[F_HOUR];
  assign wdayQ = fq[F_WDAY];
  assign dayQ  = fq[F_DAY];
  assign monQ  = fq[F_MON];
  assign yearQ = fq[F_YEAR];

  always_comb begin
    secWrap = (secQ == 8'h59);
    minWrap = (minQ == 8'h59);
    dayEnd  = monthEnd(monQ, yearQ);
    dayWrap = (dayQ == dayEnd);
    hourInc = bcdInc({2'b00, hourQ[5:0]});

    if (strb.mode24) begin
      dayFromHour = (hourQ[5:0] == 6'h23);
      hourNext    = dayFromHour ? 8'h00 : hourInc;
    end else begin
      dayFromHour = (hourQ[5:0] == 6'h11) && hourQ[6];
      if (hourQ[5:0] == 6'h11)      hourNext = {1'b0, ~hourQ[6], 6'h12};
      else if (hourQ[5:0] == 6'h12) hourNext = {1'b0, hourQ[6], 6'h01};
      else                          hourNext = {1'b0, hourQ[6], hourInc[5:0]};
    end

    stepEn[F_SEC]  = strb.advance;
    stepEn[F_MIN]  = strb.advance && secWrap;
    stepEn[F_HOUR] = stepEn[F_MIN] && minWrap;
    dayCarry       = stepEn[F_HOUR] && dayFromHour;
    stepEn[F_WDAY] = dayCarry;
    stepEn[F_DAY]  = dayCarry;
    stepEn[F_MON]  = dayCarry && dayWrap;
    stepEn[F_YEAR] = stepEn[F_MON] && (monQ == 8'h12);

    stepVal[F_SEC]  = secWrap ? 8'h00 : bcdInc(secQ);
    stepVal[F_MIN]  = minWrap ? 8'h00 : bcdInc(minQ);
    stepVal[F_HOUR] = hourNext;
    stepVal[F_WDAY] = (wdayQ == 8'h06) ? 8'h00 : wdayQ + 8'h01;
    stepVal[F_DAY]  = dayWrap ? 8'h01 : bcdInc(dayQ);
    stepVal[F_MON]  = (monQ == 8'h12) ? 8'h01 : bcdInc(monQ);
    stepVal[F_YEAR] = (yearQ == 8'h99) ? 8'h00 : bcdInc(yearQ);
  end

  generate
    for (genvar i = 0; i < FIELD_CNT; i++) begin : gField
      localparam logic [7:0] BASE = (i == F_DAY || i == F_MON) ? 8'h01 : 8'h00;
      localparam logic [7:0] PWR  = (i == F_HOUR) ? 8'h12 : BASE;
      logic [7:0] q;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              q <= PWR;
        else if (strb.clear)    q <= (i == F_HOUR && !strb.mode24) ? 8'h12 : BASE;
        else if (strb.load[i])  q <= strb.data & fieldMask(i);
        else if (stepEn[i])     q <= stepVal[i];
      end

      assign fq[i]               = q;
      assign fieldsFlat[i*8 +: 8] = q;
    end
  endgenerate

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && secQ == 8'h59) |=> (secQ == 8'h00)) else $error("seconds wrap"); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && !strb.clear && strb.load == '0) |=> $stable(fieldsFlat)) else $error("field moved"); // R9

  AST_CLEAR_VALUES: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (secQ == 8'h00 && minQ == 8'h00 && dayQ == 8'h01 && monQ == 8'h01 && yearQ == 8'h00))
    else $error("clear values"); // R11

  AST_PM_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.mode24 && secQ == 8'h59 && minQ == 8'h59 && hourQ[5:0] == 6'h11)
    |=> (hourQ[5:0] == 6'h12 && hourQ[6] != $past(hourQ[6]))) else $error("pm toggle"); // R4

endmodule

// File: rtl/bcd_clock_calendar.sv
module bcd_clock_calendar
  import cal_pkg::*;
#(
  parameter int SYNC_STAGES = 3,
  parameter int CLR_CYCLES  = 16,
  parameter int ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData
);

  calStrobe_t             strb;
  logic                   runActive, clrBusy, mode24, carryFlag;
  logic [FIELD_CNT*8-1:0] fieldsFlat;

  cal_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .CLR_CYCLES (CLR_CYCLES),
    .ADDR_W     (ADDR_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .wrEn     (wrEn),
    .addr     (addr),
    .wrData   (wrData),
    .strb     (strb),
    .runActive(runActive),
    .clrBusy  (clrBusy),
    .mode24   (mode24),
    .carryFlag(carryFlag)
  );

  cal_datapath uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .fieldsFlat(fieldsFlat)
  );

  always_comb begin
    rdData = 8'h00;
    for (int i = 0; i < FIELD_CNT; i++) begin
      if (addr == ADDR_W'(i)) rdData = fieldsFlat[i*8 +: 8];
    end
    if (addr == ADDR_W'(A_CTRL)) rdData = {1'b0, mode24, 4'b0000, clrBusy, runActive};
    if (addr == ADDR_W'(A_STAT)) rdData = {6'b000000, carryFlag, 1'b0};
  end

endmodule

// File: tb/bcd_clock_calendar_test.sv
module bcd_clock_calendar_test;

  localparam int SYNC = 2;
  localparam int CLR  = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wrData = 8'h00;
  wire  [7:0] rdData;

  int errors = 0;
  int checks = 0;

  // Reference calendar held in binary.
  int mSec, mMin, mHr, mWd, mDay, mMon, mYr;
  bit mPm, m24;

  bcd_clock_calendar #(.SYNC_STAGES(SYNC), .CLR_CYCLES(CLR), .ADDR_W(4)) uut (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  always #4 clk = ~clk;

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [7:0] toBcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] expField(int idx);
    logic [7:0] h;
    case (idx)
      0: return toBcd(mSec);
      1: return toBcd(mMin);
      2: begin
        h = toBcd(mHr);
        return m24 ? h : {1'b0, mPm, h[5:0]};
      end
      3: return toBcd(mWd);
      4: return toBcd(mDay);
      5: return toBcd(mMon);
      default: return toBcd(mYr);
    endcase
  endfunction

  task automatic modelDay();
    mWd = (mWd + 1) % 7;
    mDay++;
    if (mDay > dim(mMon, mYr)) begin
      mDay = 1;
      mMon++;
      if (mMon == 13) begin
        mMon = 1;
        mYr = (mYr + 1) % 100;
      end
    end
  endtask

  task automatic modelTick();
    mSec++;
    if (mSec == 60) begin
      mSec = 0;
      mMin++;
      if (mMin == 60) begin
        mMin = 0;
        if (m24) begin
          mHr++;
          if (mHr == 24) begin mHr = 0; modelDay(); end
        end else if (mHr == 11) begin
          mHr = 12;
          mPm = !mPm;
          if (!mPm) modelDay();
        end else if (mHr == 12) mHr = 1;
        else mHr++;
      end
    end
  endtask

  task automatic modelReset();
    mSec = 0; mMin = 0; mHr = m24 ? 0 : 12; mPm = 0;
    mWd = 0; mDay = 1; mMon = 1; mYr = 0;
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdData;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseTick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic checkAll(string req);
    logic [7:0] v;
    for (int i = 0; i < 7; i++) begin
      rd(4'(i), v);
      check(req, v, expField(i), $sformatf("field %0d", i));
    end
  endtask

  task automatic loadModel();
    for (int i = 0; i < 7; i++) wr(4'(i), expField(i));
  endtask

  task automatic setRun(bit run);
    logic [7:0] v;
    wr(4'h8, {1'b0, m24, 5'b00000, run});
    for (int k = 0; k < 20; k++) begin
      rd(4'h8, v);
      if (v[0] == run) break;
      @(negedge clk);
    end
    check("R8", {7'b0, v[0]}, {7'b0, run}, "run readback");
  endtask

  task automatic tickCase(string req, int hr, bit pm, int mn, int sc,
                          int wd, int dy, int mo, int yr);
    mHr = hr; mPm = pm; mMin = mn; mSec = sc;
    mWd = wd; mDay = dy; mMon = mo; mYr = yr;
    loadModel();
    setRun(1'b1);
    pulseTick();
    modelTick();
    checkAll(req);
    setRun(1'b0);
  endtask

  initial begin
    logic [7:0] v;
    int n;
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    m24 = 0;
    modelReset();
    checkAll("R1");
    rd(4'h8, v); check("R1", v, 8'h00, "control");
    rd(4'h9, v); check("R1", v, 8'h00, "status");

    // R8: start latency of SYNC cycles
    wr(4'h8, 8'h01);
    rd(4'h8, v); check("R8", v, 8'h00, "readback right after start");
    repeat (SYNC - 1) @(negedge clk);
    rd(4'h8, v); check("R8", v, 8'h00, "readback one cycle early");
    @(negedge clk);
    rd(4'h8, v); check("R8", v, 8'h01, "readback after latency");

    pulseTick();
    modelTick();
    checkAll("R2");

    // R10: carry flag handling
    rd(4'h9, v); check("R10", v, 8'h02, "carry after tick");
    wr(4'h9, 8'h02);
    rd(4'h9, v); check("R10", v, 8'h02, "write of one ignored");
    wr(4'h9, 8'h00);
    rd(4'h9, v); check("R10", v, 8'h00, "cleared");

    // R9: field write while running is ignored
    wr(4'h0, 8'h45);
    rd(4'h0, v); check("R9", v, expField(0), "sec write while running");

    // R8: ticks ignored once stopped
    setRun(1'b0);
    pulseTick();
    checkAll("R8");
    rd(4'h9, v); check("R8", v, 8'h00, "no carry while stopped");

    // 24-hour directed corners
    m24 = 1;
    wr(4'h8, 8'h40);
    tickCase("R5", 23, 0, 59, 59, 6, 31, 12, 99);
    tickCase("R7", 23, 0, 59, 59, 3, 15, 6, 10);
    tickCase("R6", 23, 0, 59, 59, 1, 28, 2, 24);
    tickCase("R6", 23, 0, 59, 59, 1, 28, 2, 23);
    tickCase("R6", 23, 0, 59, 59, 1, 29, 2, 0);
    tickCase("R5", 23, 0, 59, 59, 2, 30, 4, 21);
    tickCase("R3", 9, 0, 59, 59, 2, 10, 7, 45);
    tickCase("R3", 22, 0, 59, 59, 2, 10, 7, 45);
    tickCase("R2", 0, 0, 9, 59, 2, 10, 7, 45);
    tickCase("R2", 0, 0, 0, 9, 2, 10, 7, 45);

    // 12-hour directed corners
    m24 = 0;
    wr(4'h8, 8'h00);
    tickCase("R4", 11, 0, 59, 59, 2, 10, 3, 5);
    tickCase("R4", 11, 1, 59, 59, 3, 31, 1, 5);
    tickCase("R4", 12, 1, 59, 59, 3, 5, 1, 5);
    tickCase("R4", 12, 0, 59, 59, 3, 5, 1, 5);

    // Random legal dates in both modes
    for (int it = 0; it < 40; it++) begin
      m24 = $urandom_range(0, 1);
      wr(4'h8, {1'b0, m24, 6'b000000});
      mYr = $urandom_range(0, 99);
      mMon = $urandom_range(1, 12);
      mDay = ($urandom_range(0, 1) == 1) ? dim(mMon, mYr) : $urandom_range(1, dim(mMon, mYr));
      mWd = $urandom_range(0, 6);
      mPm = $urandom_range(0, 1);
      if (m24) mHr = ($urandom_range(0, 1) == 1) ? 23 : $urandom_range(0, 23);
      else     mHr = ($urandom_range(0, 1) == 1) ? 11 : $urandom_range(1, 12);
      mMin = ($urandom_range(0, 2) != 0) ? 59 : $urandom_range(0, 59);
      mSec = $urandom_range(57, 59);
      loadModel();
      setRun(1'b1);
      n = $urandom_range(1, 3);
      for (int t = 0; t < n; t++) begin
        pulseTick();
        modelTick();
        checkAll(m24 ? "R3" : "R4");
      end
      setRun(1'b0);
    end

    // R11: clear request while running in 24-hour mode
    m24 = 1;
    wr(4'h8, 8'h40);
    mHr = 15; mMin = 30; mSec = 20; mWd = 4; mDay = 17; mMon = 9; mYr = 33;
    loadModel();
    setRun(1'b1);
    wr(4'h8, 8'h43);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      rd(4'h8, v);
      if (!v[1]) break;
      n++;
      @(negedge clk);
    end
    check("R11", 8'(n), 8'(CLR), "busy cycles");
    modelReset();
    checkAll("R11");
    rd(4'h8, v); check("R11", v, 8'h41, "control after clear");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule